// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns bytes from a transmit queue into asynchronous serial frames on a single output line. The frame layout is chosen at run time. The settings are the level the line rests at, how many data bits are sent (5 to 8), whether a parity bit is added and of which kind, one or two stop bits, and the length of every bit in system clocks.

When the block is idle and the queue offers a byte, the block pops it in the same cycle. It copies the byte and the whole configuration into its own registers and starts driving the frame on the next clock. If the queue still holds data when the last stop bit ends, the next byte is popped in that final cycle, so the next frame starts with no gap on the line. A status output stays high for as long as a frame is on the line.

Top module: `sfr_tx`

## Requirements
- R1: While tx_busy is low, tx_line equals cfg_idle; tx_busy is low after reset.
- R2: A frame begins in the clock cycle after the q_pop cycle, with a start bit at the inverse of the idle level sampled at the pop.
- R3: Data bits follow the start bit, least significant first. Their count comes from the 4-bit cfg_width field: values 5 to 8 are used as given, values below 5 act as 5 and values above 8 act as 8. Data bits above that count never reach the line.
- R4: When cfg_par_en is 1, one parity bit follows the last data bit. cfg_par_odd = 0 gives even parity and 1 gives odd parity, both computed over the sent data bits only.
- R5: cfg_stop = 2'b10 gives two stop bits and any other value gives one. Stop bits are driven at the idle level.
- R6: Every bit of the frame lasts cfg_period clock cycles. A cfg_period of 0 behaves as 1.
- R7: tx_busy is high from the first start-bit cycle through the last stop-bit cycle, and low right after it unless another frame follows.
- R8: q_pop is high exactly when q_valid is high and either the block is idle or the current cycle is the final cycle of a frame. A pop in a frame's final cycle makes the next start bit follow with no idle cycle.
- R9: The configuration is sampled only at the pop. Changing it during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idle | input | 1 | Line rest level |
| cfg_width | input | WIDTH_FLD_W (4) | Number of data bits, 5 to 8 |
| cfg_par_en | input | 1 | Add a parity bit |
| cfg_par_odd | input | 1 | 0 even parity, 1 odd parity |
| cfg_stop | input | 2 | 2'b10 two stop bits, otherwise one |
| cfg_period | input | PERIOD_W (16) | Bit length in clock cycles |
| q_valid | input | 1 | Queue holds a byte |
| q_data | input | MAX_WORD (8) | Byte at the head of the queue |
| q_pop | output | 1 | Takes the head byte this cycle |
| tx_line | output | 1 | Serial output |
| tx_busy | output | 1 | A frame is in progress |

## Verification
The bench builds the block with its default parameters: an 8-bit maximum word, a 4-bit width field and a 16-bit period. It keeps the programmed bit periods small (0 to 7), so the complete product of idle level, width, parity mode and stop count can be swept cycle by cycle within a short run. The small periods also make the out-of-range width codes, the unused stop codes, a zero period, mid-frame configuration changes and a three-frame back-to-back chain cheap enough to cover in full.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
   localparam int unsigned MIN_WORD  = 5;
   localparam logic [1:0]  STOP_TWO  = 2'b10;

   // start + data + parity + two stop bits
   function automatic int unsigned frame_bits(input int unsigned max_word);
      return 1 + max_word + 1 + 2;
   endfunction
endpackage

// File: rtl/sfr_frame_build.sv
module sfr_frame_build #(
   parameter int unsigned MAX_WORD    = 8,
   parameter int unsigned WIDTH_FLD_W = 4,
   parameter int unsigned FRAME_W     = 12,
   parameter int unsigned CNT_W       = 4
) (
   input  logic [MAX_WORD-1:0]    data,
   input  logic [WIDTH_FLD_W-1:0] width_fld,
   input  logic                   par_en,
   input  logic                   par_odd,
   input  logic [1:0]             stop_fld,
   input  logic                   idle,
   output logic [FRAME_W-1:0]     frame,
   output logic [CNT_W-1:0]       nbits
);
   import sfr_pkg::*;

   logic [CNT_W-1:0]    w_eff;
   logic [MAX_WORD-1:0] mask;
   logic                par_bit;

   always_comb begin
      if (32'(width_fld) < MIN_WORD)      w_eff = CNT_W'(MIN_WORD);
      else if (32'(width_fld) > MAX_WORD) w_eff = CNT_W'(MAX_WORD);
      else                                w_eff = CNT_W'(width_fld);
   end

   for (genvar i = 0; i < MAX_WORD; i++) begin : g_mask
      assign mask[i] = (CNT_W'(i) < w_eff);
   end

   assign par_bit = (^(data & mask)) ^ par_odd;

   always_comb begin
      frame    = {FRAME_W{idle}};
      frame[0] = ~idle;
      for (int i = 0; i < int'(MAX_WORD); i++) begin
         if (mask[i]) frame[1+i] = data[i];
      end
      if (par_en) frame[1 + 32'(w_eff)] = par_bit;
      nbits = CNT_W'(1) + w_eff + CNT_W'(par_en) +
              ((stop_fld == STOP_TWO) ? CNT_W'(2) : CNT_W'(1));
   end
endmodule

// File: rtl/sfr_bit_timer.sv
module sfr_bit_timer #(
   parameter int unsigned PERIOD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                run,
   input  logic [PERIOD_W-1:0] period_in,
   output logic                tick
);
   logic [PERIOD_W-1:0] per_q;
   logic [PERIOD_W-1:0] cnt;
   logic [PERIOD_W-1:0] per_eff;

   assign per_eff = (period_in == '0) ? PERIOD_W'(1) : period_in;
   assign tick    = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q <= PERIOD_W'(1);
         cnt   <= '0;
      end else if (load) begin
         per_q <= per_eff;
         cnt   <= per_eff - PERIOD_W'(1);
      end else if (run) begin
         if (tick) cnt <= per_q - PERIOD_W'(1);
         else      cnt <= cnt - PERIOD_W'(1);
      end
   end
endmodule

// File: rtl/sfr_shifter.sv
module sfr_shifter #(
   parameter int unsigned FRAME_W = 12,
   parameter int unsigned CNT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic [CNT_W-1:0]   nbits_in,
   input  logic               idle_in,
   output logic               ser_bit,
   output logic               last,
   output logic               busy
);
   logic [FRAME_W-1:0] sh;
   logic [CNT_W-1:0]   left;
   logic               fill;

   assign ser_bit = sh[0];
   assign last    = (left == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         left <= '0;
         busy <= 1'b0;
         fill <= 1'b1;
      end else if (load) begin
         sh   <= frame_in;
         left <= nbits_in - CNT_W'(1);
         busy <= 1'b1;
         fill <= idle_in;
      end else if (step) begin
         if (last) begin
            busy <= 1'b0;
         end else begin
            sh   <= {fill, sh[FRAME_W-1:1]};
            left <= left - CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/sfr_tx.sv
module sfr_tx #(
   parameter int unsigned MAX_WORD    = 8,
   parameter int unsigned WIDTH_FLD_W = 4,
   parameter int unsigned PERIOD_W    = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_idle,
   input  logic [WIDTH_FLD_W-1:0] cfg_width,
   input  logic                   cfg_par_en,
   input  logic                   cfg_par_odd,
   input  logic [1:0]             cfg_stop,
   input  logic [PERIOD_W-1:0]    cfg_period,
   input  logic                   q_valid,
   input  logic [MAX_WORD-1:0]    q_data,
   output logic                   q_pop,
   output logic                   tx_line,
   output logic                   tx_busy
);
   import sfr_pkg::*;

   localparam int unsigned FRAME_W = frame_bits(MAX_WORD);
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

   if (MAX_WORD < MIN_WORD) begin : g_bad_word
      $error("sfr_tx: MAX_WORD must be at least MIN_WORD");
   end
   if ((1 << WIDTH_FLD_W) <= MAX_WORD) begin : g_bad_fld
      $error("sfr_tx: WIDTH_FLD_W too narrow to encode MAX_WORD");
   end
   if (PERIOD_W < 1) begin : g_bad_per
      $error("sfr_tx: PERIOD_W must be positive");
   end

   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   nbits;
   logic               tick;
   logic               ser_bit;
   logic               last;
   logic               frame_end;

   sfr_frame_build #(
      .MAX_WORD(MAX_WORD), .WIDTH_FLD_W(WIDTH_FLD_W),
      .FRAME_W(FRAME_W), .CNT_W(CNT_W)
   ) u_build (
      .data(q_data), .width_fld(cfg_width), .par_en(cfg_par_en),
      .par_odd(cfg_par_odd), .stop_fld(cfg_stop), .idle(cfg_idle),
      .frame(frame), .nbits(nbits)
   );

   sfr_bit_timer #(.PERIOD_W(PERIOD_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(q_pop), .run(tx_busy),
      .period_in(cfg_period), .tick(tick)
   );

   sfr_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(q_pop), .step(tx_busy & tick),
      .frame_in(frame), .nbits_in(nbits), .idle_in(cfg_idle),
      .ser_bit(ser_bit), .last(last), .busy(tx_busy)
   );

   assign frame_end = tx_busy & tick & last;
   assign q_pop     = q_valid & (~tx_busy | frame_end);
   assign tx_line   = tx_busy ? ser_bit : cfg_idle;
endmodule

// File: rtl/sfr_tx_chk.sv
module sfr_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_idle,
   input logic q_valid,
   input logic q_pop,
   input logic tx_line,
   input logic tx_busy
);
   // R1
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> (tx_line == cfg_idle));

   // R2
   start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_pop |=> (tx_busy && (tx_line == !$past(cfg_idle))));

   // R8
   pop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_pop |-> q_valid);

   // R8
   idle_pops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_busy && q_valid) |-> q_pop);

   // R7
   end_without_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_busy) |-> !$past(q_pop));
endmodule

bind sfr_tx sfr_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_idle(cfg_idle), .q_valid(q_valid),
   .q_pop(q_pop), .tx_line(tx_line), .tx_busy(tx_busy)
);

// File: tb/sfr_tx_tb.sv
`timescale 1ns/1ps
module sfr_tx_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_idle = 1'b1;
   logic [3:0]  cfg_width = 4'd8;
   logic        cfg_par_en = 1'b0;
   logic        cfg_par_odd = 1'b0;
   logic [1:0]  cfg_stop = 2'b01;
   logic [15:0] cfg_period = 16'd1;
   logic        q_valid = 1'b0;
   logic [7:0]  q_data = 8'h00;
   logic        q_pop, tx_line, tx_busy;
   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   sfr_tx u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_idle(cfg_idle), .cfg_width(cfg_width),
      .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop),
      .cfg_period(cfg_period), .q_valid(q_valid), .q_data(q_data),
      .q_pop(q_pop), .tx_line(tx_line), .tx_busy(tx_busy)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int build(input logic idle, input logic [3:0] wf,
                                input logic pe, input logic po,
                                input logic [1:0] sf, input logic [7:0] d,
                                output logic [15:0] bits);
      int wi;
      logic [7:0] m;
      wi = (wf < 4'd5) ? 5 : ((wf > 4'd8) ? 8 : int'(wf));
      m = 8'((1 << wi) - 1);
      bits = {16{idle}};
      bits[0] = ~idle;
      for (int i = 0; i < wi; i++) bits[1+i] = d[i];
      if (pe) bits[1+wi] = (^(d & m)) ^ po;
      return 1 + wi + int'(pe) + ((sf == 2'b10) ? 2 : 1);
   endfunction

   // Called at the negedge right after the loading edge.
   task automatic play(input string tag, input logic idle, input logic [3:0] wf,
                       input logic pe, input logic po, input logic [1:0] sf,
                       input logic [15:0] per, input logic [7:0] d,
                       input bit chain);
      logic [15:0] bits;
      int nb, p, wi, busy_bad, pop_bad;
      string req;
      nb = build(idle, wf, pe, po, sf, d, bits);
      p  = (per == 16'd0) ? 1 : int'(per);
      wi = (wf < 4'd5) ? 5 : ((wf > 4'd8) ? 8 : int'(wf));
      busy_bad = 0;
      pop_bad  = 0;
      for (int b = 0; b < nb; b++) begin
         int line_bad;
         line_bad = 0;
         for (int c = 0; c < p; c++) begin
            if (tx_line !== bits[b]) line_bad++;
            if (tx_busy !== 1'b1) busy_bad++;
            if ((b == nb-1) && (c == p-1)) begin
               if (q_pop !== chain) pop_bad++;
            end else if (q_pop !== 1'b0) pop_bad++;
            @(negedge clk);
         end
         if (b == 0)                       req = "R2";
         else if (b <= wi)                 req = "R3";
         else if (pe && (b == wi + 1))     req = "R4";
         else                              req = "R5";
         chk(req, $sformatf("%s bit %0d line mismatches", tag, b), line_bad, 0);
      end
      chk("R7", {tag, " busy during frame"}, busy_bad, 0);
      chk("R8", {tag, " pop timing"}, pop_bad, 0);
      if (!chain) begin
         chk("R7", {tag, " busy after frame"}, tx_busy, 0);
         chk("R1", {tag, " line idle after frame"}, tx_line, cfg_idle);
      end
   endtask

   // Starts a lone frame from idle; optionally scrambles config mid-frame.
   task automatic launch(input string tag, input logic idle, input logic [3:0] wf,
                         input logic pe, input logic po, input logic [1:0] sf,
                         input logic [15:0] per, input logic [7:0] d,
                         input bit scramble);
      cfg_idle = idle; cfg_width = wf; cfg_par_en = pe; cfg_par_odd = po;
      cfg_stop = sf; cfg_period = per; q_data = d; q_valid = 1'b1;
      #1;
      chk("R8", {tag, " pop when idle and valid"}, q_pop, 1);
      @(negedge clk);
      q_valid = 1'b0;
      q_data  = ~d;
      if (scramble) begin
         cfg_idle = ~idle; cfg_width = 4'd13 - wf; cfg_par_en = ~pe;
         cfg_par_odd = ~po; cfg_stop = ~sf; cfg_period = per + 16'd2;
      end
      play(tag, idle, wf, pe, po, sf, per, d, 1'b0);
   endtask

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int k;
      repeat (3) @(negedge clk);
      chk("R1", "line in reset", tx_line, 1);
      chk("R7", "busy in reset", tx_busy, 0);
      chk("R8", "pop in reset", q_pop, 0);
      rst_n = 1'b1;
      @(negedge clk);
      cfg_idle = 1'b0;
      #1;
      chk("R1", "line follows idle level 0", tx_line, 0);
      repeat (4) @(negedge clk);
      chk("R8", "no pop without valid", q_pop, 0);
      chk("R7", "stays idle without valid", tx_busy, 0);

      // Full sweep of idle, width, parity mode and stop count (R9 scrambles)
      k = 0;
      for (int id = 0; id < 2; id++)
         for (int w = 5; w <= 8; w++)
            for (int pm = 0; pm < 3; pm++)
               for (int s = 0; s < 2; s++) begin
                  launch("R9 sweep", 1'(id), 4'(w), 1'(pm != 0), 1'(pm == 2),
                         (s != 0) ? 2'b10 : 2'b01, 16'(1 + (k % 3)),
                         8'(k * 37 + 91), 1'b1);
                  k++;
               end

      // R3 width clamping and upper bits dropped
      launch("R3 width3", 1'b1, 4'd3, 1'b1, 1'b0, 2'b01, 16'd2, 8'hE5, 1'b0);
      launch("R3 width15", 1'b1, 4'd15, 1'b1, 1'b1, 2'b01, 16'd1, 8'h96, 1'b0);
      launch("R3 width5 high bits", 1'b0, 4'd5, 1'b0, 1'b0, 2'b01, 16'd1, 8'hE0, 1'b0);
      // R5 unused stop codes
      launch("R5 stop00", 1'b1, 4'd6, 1'b0, 1'b0, 2'b00, 16'd2, 8'h2A, 1'b0);
      launch("R5 stop11", 1'b0, 4'd7, 1'b1, 1'b0, 2'b11, 16'd1, 8'h55, 1'b0);
      // R6 zero and longer periods
      launch("R6 period0", 1'b1, 4'd8, 1'b0, 1'b0, 2'b01, 16'd0, 8'hA3, 1'b0);
      launch("R6 period7", 1'b1, 4'd8, 1'b1, 1'b1, 2'b10, 16'd7, 8'h3C, 1'b1);

      // R8 back-to-back chain of three frames with changing formats
      cfg_idle = 1'b1; cfg_width = 4'd8; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
      cfg_stop = 2'b01; cfg_period = 16'd2; q_data = 8'hC1; q_valid = 1'b1;
      #1;
      chk("R8", "chain first pop", q_pop, 1);
      @(negedge clk);
      q_data = 8'h5E; cfg_width = 4'd6; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
      cfg_stop = 2'b10; cfg_period = 16'd1;
      play("R8 chain f1", 1'b1, 4'd8, 1'b0, 1'b0, 2'b01, 16'd2, 8'hC1, 1'b1);
      q_data = 8'h0F; cfg_idle = 1'b0; cfg_width = 4'd5; cfg_par_en = 1'b1;
      cfg_par_odd = 1'b0; cfg_stop = 2'b01; cfg_period = 16'd3;
      play("R8 chain f2", 1'b1, 4'd6, 1'b1, 1'b1, 2'b10, 16'd1, 8'h5E, 1'b1);
      q_valid = 1'b0;
      play("R8 chain f3", 1'b0, 4'd5, 1'b1, 1'b0, 2'b01, 16'd3, 8'h0F, 1'b0);

      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule